// File: doc/BRIEF.md
# Processor Run/Stop Controller

This block starts and halts a set of processors that share a cluster. Software writes a bitmask to a start register to bring halted processors out of halt, or to a halt register to stop running ones. A status register reports which processors are currently active. Each processor has its own reset pulse output and halt pulse output. The running state is kept inside the block and can only be read back through the status register.

Each processor is tracked by its own small state machine. It has three states: `VP_HALTED`, `VP_RESETTING` and `VP_RUNNING`. The transitions are:

- *start*: from `VP_HALTED` to `VP_RESETTING`, on a start command for a halted processor.
- *release*: from `VP_RESETTING` to `VP_RUNNING`. This is unconditional and happens one cycle later.
- *halt*: from `VP_RUNNING` to `VP_HALTED`, on a halt command for a running processor.

In every other case the state holds.

The same three registers appear in two identical address windows. The first window is based at 0x000 and the second at 0x100. Within each window the start register is at offset 0x00, the halt register at 0x08 and the status register at 0x10. On reset all processors are halted. In the first cycle after reset is released, the processors named by a start-mask parameter are started through the ordinary start path.

Top module: `vp_runstop_ctrl`

## Requirements
- R1: Only bits [NUM_PROC-1:0] of written data take effect. Higher bits of a start or halt write change no processor.
- R2: A start write sampled at clock edge E drives `vp_reset` high for exactly the cycle after E for each named processor that is in `VP_HALTED`. Such a processor reads as running from edge E+1. A processor already running gets no reset pulse.
- R3: A halt write sampled at edge E drives `vp_halt` high for exactly the cycle after E for each named processor in `VP_RUNNING`, and its running bit clears at the same edge E. A halted processor gets no halt pulse.
- R4: A status read sampled at edge E returns on `bus_rdata`, after E, the running bitmask as it was before E. The bitmask sits in bit i for processor i, and all bits at and above NUM_PROC read zero.
- R5: The window at base 0x100 behaves exactly like the window at base 0x000.
- R6: A read from any offset other than the three registers, or from outside both windows, returns zero. A write there changes no processor and pulses no output.
- R7: During reset the running bitmask is zero and both pulse outputs are low. At the first edge after reset is released, every processor in START_MASK is started as in R2.
- R8: A START_MASK with a bit set at or above NUM_PROC is rejected at elaboration.
- R9: A halt followed in the next cycle by a start for the same processor gives a halt pulse, then a fresh reset pulse, and the processor ends up running.
- R10: Commands that reach a processor while it is in `VP_RESETTING` are ignored. That processor always moves to `VP_RUNNING` next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr_en | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 64 | Write data, bit i names processor i |
| bus_rd_en | input | 1 | Read strobe, sampled at the rising edge |
| bus_rdata | output | 64 | Registered read data |
| vp_reset | output | NUM_PROC | Per-processor one-cycle reset pulse |
| vp_halt | output | NUM_PROC | Per-processor one-cycle halt pulse |

## Verification
Counting from the edge E that samples a command, the results fall due as follows:

- reset and halt pulses appear just after E;
- a started processor's running bit is visible to a read sampled at E+2 or later;
- read data appears just after the edge that samples the read.

The bench's driver records each expected pulse and read value together with the edge number it is due at. The monitor compares them at the falling edge that follows exactly that edge, and explicit zero expectations pin down the cycles where no pulse may appear.

// File: rtl/vprc_pkg.sv
package vprc_pkg;
    localparam int DATA_W    = 64;
    localparam int WIN_SHIFT = 8;
    localparam int NUM_WIN   = 2;

    localparam logic [WIN_SHIFT-1:0] OFS_START  = 8'h00;
    localparam logic [WIN_SHIFT-1:0] OFS_HALT   = 8'h08;
    localparam logic [WIN_SHIFT-1:0] OFS_STATUS = 8'h10;

    typedef enum logic [1:0] {
        VP_HALTED    = 2'd0,
        VP_RESETTING = 2'd1,
        VP_RUNNING   = 2'd2
    } vp_state_e;
endpackage

// File: rtl/vprc_decode.sv
module vprc_decode
    import vprc_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic              start_wr,
    output logic              halt_wr,
    output logic              status_rd
);
    localparam int IDX_W = ADDR_W - WIN_SHIFT;

    logic [IDX_W-1:0]     win_idx;
    logic [WIN_SHIFT-1:0] offs;
    logic                 win_ok;

    assign win_idx = addr[ADDR_W-1:WIN_SHIFT];
    assign offs    = addr[WIN_SHIFT-1:0];
    // both windows alias the same registers (R5); anything else decodes to nothing (R6)
    assign win_ok  = win_idx < IDX_W'(NUM_WIN);

    assign start_wr  = wr_en && win_ok && (offs == OFS_START);
    assign halt_wr   = wr_en && win_ok && (offs == OFS_HALT);
    assign status_rd = rd_en && win_ok && (offs == OFS_STATUS);
endmodule

// File: rtl/vprc_proc_fsm.sv
module vprc_proc_fsm
    import vprc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic stop_i,
    output logic reset_pulse_o,
    output logic halt_pulse_o,
    output logic running_o
);
    vp_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            VP_HALTED:    if (start_i) state_d = VP_RESETTING;
            VP_RESETTING: state_d = VP_RUNNING;
            VP_RUNNING:   if (stop_i) state_d = VP_HALTED;
            default:      state_d = VP_HALTED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= VP_HALTED;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) halt_pulse_o <= 1'b0;
        else        halt_pulse_o <= (state_q == VP_RUNNING) && stop_i;
    end

    assign reset_pulse_o = (state_q == VP_RESETTING);
    assign running_o     = (state_q == VP_RUNNING);

    p_reset_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reset_pulse_o |=> (!reset_pulse_o && running_o));

    p_start_via_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running_o) |-> $past(reset_pulse_o));

    p_halt_from_running_r3: assert property (@(posedge clk) disable iff (!rst_n)
        halt_pulse_o |-> ($past(running_o) && !running_o));

    p_resetting_ignores_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reset_pulse_o && stop_i) |=> (running_o && !halt_pulse_o));
endmodule

// File: rtl/vp_runstop_ctrl.sv
module vp_runstop_ctrl
    import vprc_pkg::*;
#(
    parameter int          NUM_PROC   = 1,
    parameter logic [63:0] START_MASK = 64'h1,
    parameter int          ADDR_W     = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr_en,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic                bus_rd_en,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic [NUM_PROC-1:0] vp_reset,
    output logic [NUM_PROC-1:0] vp_halt
);
    localparam logic [DATA_W-1:0] VALID_MASK = {DATA_W{1'b1}} >> (DATA_W - NUM_PROC);

    // R8: start mask must fit inside the processor count
    if (START_MASK > VALID_MASK) begin : g_bad_start_mask_r8
        $error("START_MASK has bits beyond NUM_PROC");
    end

    logic                start_wr, halt_wr, status_rd;
    logic                boot_q;
    logic [DATA_W-1:0]   wdata_masked;
    logic                unused_wdata_hi;
    logic [NUM_PROC-1:0] start_vec, stop_vec, running_vec;

    vprc_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr      (bus_addr),
        .wr_en     (bus_wr_en),
        .rd_en     (bus_rd_en),
        .start_wr  (start_wr),
        .halt_wr   (halt_wr),
        .status_rd (status_rd)
    );

    // one-shot start request in the first cycle after reset release (R7)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) boot_q <= 1'b1;
        else        boot_q <= 1'b0;
    end

    assign wdata_masked    = bus_wdata & VALID_MASK;            // R1
    assign unused_wdata_hi = ^(bus_wdata & ~VALID_MASK);
    assign start_vec = (start_wr ? wdata_masked[NUM_PROC-1:0] : '0)
                     | (boot_q ? START_MASK[NUM_PROC-1:0] : '0);
    assign stop_vec  = halt_wr ? wdata_masked[NUM_PROC-1:0] : '0;

    for (genvar i = 0; i < NUM_PROC; i++) begin : g_proc
        vprc_proc_fsm u_fsm (
            .clk           (clk),
            .rst_n         (rst_n),
            .start_i       (start_vec[i]),
            .stop_i        (stop_vec[i]),
            .reset_pulse_o (vp_reset[i]),
            .halt_pulse_o  (vp_halt[i]),
            .running_o     (running_vec[i])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         bus_rdata <= '0;
        else if (status_rd) bus_rdata <= DATA_W'(running_vec);
        else                bus_rdata <= '0;
    end

    p_rdata_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata & ~VALID_MASK) == '0);

    p_no_reset_and_halt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (vp_reset & vp_halt) == '0);

    p_boot_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        boot_q |=> (vp_reset == START_MASK[NUM_PROC-1:0]));
endmodule

// File: tb/vp_runstop_ctrl_tb_top.sv
module vp_runstop_ctrl_tb_top;
    localparam int          NP    = 4;
    localparam logic [63:0] START = 64'h5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr_en = 1'b0;
    logic [63:0] bus_wdata = '0;
    logic        bus_rd_en = 1'b0;
    logic [63:0] bus_rdata;
    logic [NP-1:0] vp_reset, vp_halt;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        int          due;
        int          kind;   // 0 reset pulses, 1 halt pulses, 2 read data
        logic [63:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];

    vp_runstop_ctrl #(.NUM_PROC(NP), .START_MASK(START), .ADDR_W(12)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
        .bus_wdata(bus_wdata), .bus_rd_en(bus_rd_en), .bus_rdata(bus_rdata),
        .vp_reset(vp_reset), .vp_halt(vp_halt)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic expect_at(input int due, input int kind, input logic [63:0] exp, input string tag);
        item_t it;
        it.due = due; it.kind = kind; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
    endtask

    // monitor: compare every item due at the edge just passed
    always @(negedge clk) begin
        for (int i = sb_q.size() - 1; i >= 0; i--) begin
            if (sb_q[i].due == cyc) begin
                case (sb_q[i].kind)
                    0:       check(64'(vp_reset), sb_q[i].exp, {sb_q[i].tag, " reset"});
                    1:       check(64'(vp_halt), sb_q[i].exp, {sb_q[i].tag, " halt"});
                    default: check(bus_rdata, sb_q[i].exp, {sb_q[i].tag, " read"});
                endcase
                sb_q.delete(i);
            end
        end
    end

    task automatic bus_wr(input logic [11:0] a, input logic [63:0] d, output int e);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1; bus_rd_en = 1'b0;
        e = cyc + 1;
    endtask

    task automatic bus_rd(input logic [11:0] a, input logic [63:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a; bus_wr_en = 1'b0; bus_rd_en = 1'b1;
        expect_at(cyc + 1, 2, exp, tag);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        bus_wr_en = 1'b0; bus_rd_en = 1'b0;
        for (int k = 1; k < n; k++) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        int e, e2;
        repeat (3) @(negedge clk);
        check(64'(vp_reset), 64'h0, "R7 reset state");
        check(64'(vp_halt), 64'h0, "R7 reset state");
        check(bus_rdata, 64'h0, "R7 reset state");
        rst_n = 1'b1;
        expect_at(cyc + 1, 0, START, "R7 R8 boot start");
        expect_at(cyc + 1, 1, 64'h0, "R7 boot");
        expect_at(cyc + 2, 0, 64'h0, "R7 boot end");
        idle(3);
        bus_rd(12'h010, START, "R7 running after boot");

        // R1 R2: start all, bits above NP ignored; running ones not re-reset
        bus_wr(12'h000, '1, e);
        expect_at(e, 0, 64'hA, "R1 R2 start halted only");
        expect_at(e + 1, 0, 64'h0, "R2 single pulse");
        idle(1);
        bus_rd(12'h110, 64'hF, "R5 R4 status alias");

        // R3 R5: halt through the second window
        bus_wr(12'h108, 64'h3, e);
        expect_at(e, 1, 64'h3, "R3 R5 halt pulse");
        expect_at(e, 0, 64'h0, "R3 no reset");
        expect_at(e + 1, 1, 64'h0, "R3 single halt");
        idle(1);
        bus_rd(12'h010, 64'hC, "R3 running cleared");

        // R3: halt of halted processors has no effect
        bus_wr(12'h008, 64'h3, e);
        expect_at(e, 1, 64'h0, "R3 halted ignored");
        idle(1);
        bus_rd(12'h010, 64'hC, "R3 status unchanged");

        // R6: unimplemented offsets and out-of-window addresses
        bus_wr(12'h018, 64'hF, e);
        expect_at(e, 0, 64'h0, "R6 bad offset");
        expect_at(e, 1, 64'h0, "R6 bad offset");
        bus_wr(12'h208, 64'hF, e);
        expect_at(e, 1, 64'h0, "R6 outside window halt");
        bus_wr(12'h200, 64'hF, e);
        expect_at(e, 0, 64'h0, "R6 outside window start");
        idle(1);
        bus_rd(12'h018, 64'h0, "R6 bad offset read");
        bus_rd(12'h210, 64'h0, "R6 outside window read");
        bus_rd(12'h010, 64'hC, "R6 status unchanged");

        // R9: halt then start on consecutive cycles
        bus_wr(12'h008, 64'h4, e);
        expect_at(e, 1, 64'h4, "R9 halt");
        bus_wr(12'h100, 64'h4, e2);
        expect_at(e2, 0, 64'h4, "R9 fresh reset");
        expect_at(e2, 1, 64'h0, "R9 halt ended");
        expect_at(e2 + 1, 0, 64'h0, "R9 reset ended");
        idle(2);
        bus_rd(12'h010, 64'hC, "R9 running again");

        // R10: halt while resetting is ignored
        bus_wr(12'h000, 64'h1, e);
        expect_at(e, 0, 64'h1, "R10 start");
        bus_wr(12'h008, 64'h1, e2);
        expect_at(e2, 1, 64'h0, "R10 no halt");
        expect_at(e2 + 1, 1, 64'h0, "R10 no halt later");
        idle(1);
        bus_rd(12'h010, 64'hD, "R10 still running");

        // R2: start of mixed set only resets the halted one
        bus_wr(12'h100, 64'hF, e);
        expect_at(e, 0, 64'h2, "R2 mixed start");
        idle(1);
        bus_rd(12'h110, 64'hF, "R2 all running");

        // R1: halt bits only above NP
        bus_wr(12'h008, 64'hFFFF_FFFF_FFFF_FFF0, e);
        expect_at(e, 1, 64'h0, "R1 high bits ignored");
        idle(1);
        bus_rd(12'h010, 64'hF, "R1 status unchanged");

        idle(4);
        checks += sb_q.size();
        errors += sb_q.size();
        if (sb_q.size() != 0) $display("FAIL scoreboard: actual %0d pending expected 0", sb_q.size());
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end
endmodule